// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address by reading descriptors from a translation table held in memory. A client offers a request with the virtual address, the base of the first-level table and a flag that allows tiny pages. The walker then fetches one or two 32-bit descriptors through a single-outstanding read port. It returns the physical address, a two-bit cacheable/bufferable attribute and a fault flag, all qualified by a one-cycle `done` pulse.

A first-level descriptor can map a 1 MiB section directly, or it can point to a coarse second-level table (256 entries) or a fine one (1024 entries). A second-level descriptor maps a 64 KiB large page, a 4 KiB small page or a 1 KiB tiny page. Section results need only one read. The walker holds only one walk at a time, and all of a walk's inputs are latched when the request is taken.

Top module: `xlate_walker`

## Requirements
- R1: The first read of a walk goes to address {ttb[31:14], va[31:20], 2'b00}.
- R2: A first-level descriptor whose bits [1:0] are 00 ends the walk with fault=1 after that single read.
- R3: A first-level descriptor of type 11 (fine table) with tiny pages disabled ends the walk with fault=1, and no second read is issued.
- R4: A first-level type 10 (section) ends the walk after one read with pa = {desc[31:20], va[19:0]} and attr = desc[3:2].
- R5: For first-level type 01 (coarse table), the second read goes to {desc[31:10], va[19:12], 2'b00}.
- R6: For first-level type 11 with tiny pages enabled (fine table), the second read goes to {desc[31:12], va[19:10], 2'b00}.
- R7: A second-level descriptor with bits [1:0] = 00 gives fault=1. For any other second-level type, attr = desc[3:2].
- R8: Second-level type 01 gives pa = {desc[31:16], va[15:0]}, type 10 gives {desc[31:12], va[11:0]}, and type 11 gives {desc[31:10], va[9:0]}.
- R9: An error response on either read ends the walk with fault=1. Whenever fault=1 is reported, pa and attr are zero.
- R10: `done` is high for exactly one cycle per walk. `req_ready` is high only when no walk is active. At most one read is outstanding, and no new read is requested while a response is pending.
- R11: The virtual address, table base and tiny-page flag are latched when a request is accepted. Later changes on those inputs do not affect the walk in progress.
- R12: While `mem_rd_valid` is high and `mem_rd_ready` is low, `mem_rd_valid` stays high and `mem_rd_addr` does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Translation request offered |
| req_ready | output | 1 | Walker idle; request taken when both are high |
| req_va | input | 32 | Virtual address to translate |
| req_ttb | input | 32 | First-level table base (bits [13:0] ignored) |
| req_tiny_en | input | 1 | Allows fine tables and tiny pages |
| mem_rd_valid | output | 1 | Descriptor read request |
| mem_rd_ready | input | 1 | Memory accepts the read |
| mem_rd_addr | output | 32 | Byte address of the descriptor word |
| mem_rsp_valid | input | 1 | Read response present |
| mem_rsp_data | input | 32 | Descriptor word returned |
| mem_rsp_err | input | 1 | Response carries a bus error |
| done | output | 1 | One-cycle pulse: result outputs valid |
| fault | output | 1 | Translation failed |
| pa | output | 32 | Physical address (zero on fault) |
| attr | output | 2 | Cacheable/bufferable bits (zero on fault) |

## Verification
The bench drives every descriptor type at both levels. It also drives the fine-table encoding with tiny pages switched off, which a careless decoder would follow into a second read and translate as if it were legal. It injects bus errors on the first and the second read. A design that kept the partially built address would return a non-zero `pa` with the fault. The bench changes the request inputs in mid-walk, which exposes a walker that indexes from the live inputs rather than from latched copies. It also stalls the read port, which catches an address that moves, or a request that drops, before it is accepted. For every walk the bench counts the reads and records the address of each one, so a skipped second read or a wrong index shift or mask shows up even when the final address happens to look plausible.

// File: rtl/xlate_pkg.sv
// Package: shared encodings and field positions for the table walker.
// Assumes 32-bit descriptors and 32-bit virtual/physical addresses.
package xlate_pkg;
    localparam int unsigned ADDR_W    = 32;
    localparam int unsigned ATTR_W    = 2;
    localparam int unsigned TTB_LSB   = 14;  // first-level table alignment
    localparam int unsigned SECT_LSB  = 20;  // section / first-level index
    localparam int unsigned CRS_LSB   = 10;  // coarse table base alignment
    localparam int unsigned FINE_LSB  = 12;  // fine table base alignment
    localparam int unsigned LARGE_LSB = 16;
    localparam int unsigned SMALL_LSB = 12;
    localparam int unsigned TINY_LSB  = 10;
    localparam int unsigned TAB_W     = ADDR_W - CRS_LSB;  // kept table pointer bits

    typedef enum logic [2:0] {
        ST_IDLE, ST_L1_REQ, ST_L1_WAIT, ST_L2_REQ, ST_L2_WAIT, ST_DONE
    } walk_state_e;

    typedef enum logic [1:0] {
        L1_INVALID = 2'b00, L1_COARSE = 2'b01, L1_SECTION = 2'b10, L1_FINE = 2'b11
    } l1_kind_e;

    typedef enum logic [1:0] {
        L2_INVALID = 2'b00, L2_LARGE = 2'b01, L2_SMALL = 2'b10, L2_TINY = 2'b11
    } l2_kind_e;
endpackage

// File: rtl/xlate_addr.sv
// Module: descriptor read address generator.
// Selects between the first-level address and the coarse or fine
// second-level address. Pure combinational; inputs come from latched state.
module xlate_addr
    import xlate_pkg::*;
(
    input  logic [ADDR_W-TTB_LSB-1:0] ttb_base,
    input  logic [ADDR_W-1:CRS_LSB]   va_hi,
    input  logic [TAB_W-1:0]          tab_ptr,
    input  logic                      use_l2,
    input  logic                      fine,
    output logic [ADDR_W-1:0]         rd_addr
);
    logic [ADDR_W-1:0] l1_addr;
    logic [ADDR_W-1:0] crs_addr;
    logic [ADDR_W-1:0] fine_addr;

    // Build the three candidate word addresses and pick one.
    always_comb begin
        l1_addr   = {ttb_base, va_hi[ADDR_W-1:SECT_LSB], 2'b00};
        crs_addr  = {tab_ptr, va_hi[SECT_LSB-1:SMALL_LSB], 2'b00};
        fine_addr = {tab_ptr[TAB_W-1:FINE_LSB-CRS_LSB], va_hi[SECT_LSB-1:CRS_LSB], 2'b00};
        if (!use_l2)
            rd_addr = l1_addr;
        else if (fine)
            rd_addr = fine_addr;
        else
            rd_addr = crs_addr;
    end
endmodule

// File: rtl/xlate_l1_dec.sv
// Module: first-level descriptor decoder.
// Classifies the descriptor, applies the tiny-page gate and forms the
// section result. Assumes desc is the raw word from the read port.
module xlate_l1_dec
    import xlate_pkg::*;
(
    input  logic [ADDR_W-1:0]   desc,
    input  logic [SECT_LSB-1:0] va_lo,
    input  logic                tiny_en,
    output logic                bad,
    output logic                section,
    output logic                fine,
    output logic [ADDR_W-1:0]   sect_pa,
    output logic [ATTR_W-1:0]   sect_attr
);
    l1_kind_e kind;
    logic     unused_desc_bits;

    assign unused_desc_bits = ^desc[SECT_LSB-1:4];

    // Decode the type field and form the section translation.
    always_comb begin
        kind      = l1_kind_e'(desc[1:0]);
        bad       = (kind == L1_INVALID) || (kind == L1_FINE && !tiny_en);
        section   = (kind == L1_SECTION);
        fine      = (kind == L1_FINE);
        sect_pa   = {desc[ADDR_W-1:SECT_LSB], va_lo};
        sect_attr = desc[3:2];
    end
endmodule

// File: rtl/xlate_l2_dec.sv
// Module: second-level descriptor decoder.
// Forms the large, small or tiny page address and flags invalid entries.
module xlate_l2_dec
    import xlate_pkg::*;
(
    input  logic [ADDR_W-1:0]    desc,
    input  logic [LARGE_LSB-1:0] va_lo,
    output logic                 bad,
    output logic [ADDR_W-1:0]    page_pa,
    output logic [ATTR_W-1:0]    page_attr
);
    logic unused_desc_bits;

    assign unused_desc_bits = ^desc[TINY_LSB-1:4];

    // Splice descriptor base and page offset by page size.
    always_comb begin
        bad       = 1'b0;
        page_attr = desc[3:2];
        unique case (l2_kind_e'(desc[1:0]))
            L2_LARGE: page_pa = {desc[ADDR_W-1:LARGE_LSB], va_lo};
            L2_SMALL: page_pa = {desc[ADDR_W-1:SMALL_LSB], va_lo[SMALL_LSB-1:0]};
            L2_TINY:  page_pa = {desc[ADDR_W-1:TINY_LSB],  va_lo[TINY_LSB-1:0]};
            default: begin
                page_pa = '0;
                bad     = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/xlate_walker.sv
// Module: two-level translation table walker (top).
// Accepts one request in idle, latches its inputs, fetches one or two
// descriptors with one read outstanding, and reports with a done pulse.
// Assumes the memory returns exactly one response per accepted read.
module xlate_walker
    import xlate_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_va,
    input  logic [ADDR_W-1:0] req_ttb,
    input  logic              req_tiny_en,
    output logic              mem_rd_valid,
    input  logic              mem_rd_ready,
    output logic [ADDR_W-1:0] mem_rd_addr,
    input  logic              mem_rsp_valid,
    input  logic [ADDR_W-1:0] mem_rsp_data,
    input  logic              mem_rsp_err,
    output logic              done,
    output logic              fault,
    output logic [ADDR_W-1:0] pa,
    output logic [ATTR_W-1:0] attr
);
    walk_state_e               state_q;
    logic [ADDR_W-1:0]         va_q;
    logic [ADDR_W-TTB_LSB-1:0] ttb_q;
    logic                      tiny_q;
    logic [TAB_W-1:0]          tab_q;
    logic                      fine_q;
    logic [ADDR_W-1:0]         pa_q;
    logic [ATTR_W-1:0]         attr_q;
    logic                      fault_q;

    logic                      l1_bad, l1_sect, l1_fine;
    logic [ADDR_W-1:0]         l1_pa, l2_pa;
    logic [ATTR_W-1:0]         l1_attr, l2_attr;
    logic                      l2_bad;
    logic                      unused_ttb_bits;

    assign unused_ttb_bits = ^req_ttb[TTB_LSB-1:0];

    xlate_addr u_addr (
        .ttb_base (ttb_q),
        .va_hi    (va_q[ADDR_W-1:CRS_LSB]),
        .tab_ptr  (tab_q),
        .use_l2   (state_q == ST_L2_REQ),
        .fine     (fine_q),
        .rd_addr  (mem_rd_addr)
    );

    xlate_l1_dec u_l1 (
        .desc      (mem_rsp_data),
        .va_lo     (va_q[SECT_LSB-1:0]),
        .tiny_en   (tiny_q),
        .bad       (l1_bad),
        .section   (l1_sect),
        .fine      (l1_fine),
        .sect_pa   (l1_pa),
        .sect_attr (l1_attr)
    );

    xlate_l2_dec u_l2 (
        .desc      (mem_rsp_data),
        .va_lo     (va_q[LARGE_LSB-1:0]),
        .bad       (l2_bad),
        .page_pa   (l2_pa),
        .page_attr (l2_attr)
    );

    // Walk sequencer: captures the request, steps through reads, loads the result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            va_q    <= '0;
            ttb_q   <= '0;
            tiny_q  <= 1'b0;
            tab_q   <= '0;
            fine_q  <= 1'b0;
            pa_q    <= '0;
            attr_q  <= '0;
            fault_q <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (req_valid) begin
                    va_q    <= req_va;
                    ttb_q   <= req_ttb[ADDR_W-1:TTB_LSB];
                    tiny_q  <= req_tiny_en;
                    state_q <= ST_L1_REQ;
                end
                ST_L1_REQ: if (mem_rd_ready) state_q <= ST_L1_WAIT;
                ST_L1_WAIT: if (mem_rsp_valid) begin
                    if (mem_rsp_err || l1_bad) begin
                        {fault_q, pa_q, attr_q} <= {1'b1, {ADDR_W{1'b0}}, {ATTR_W{1'b0}}};
                        state_q <= ST_DONE;
                    end else if (l1_sect) begin
                        {fault_q, pa_q, attr_q} <= {1'b0, l1_pa, l1_attr};
                        state_q <= ST_DONE;
                    end else begin
                        tab_q   <= mem_rsp_data[ADDR_W-1:CRS_LSB];
                        fine_q  <= l1_fine;
                        state_q <= ST_L2_REQ;
                    end
                end
                ST_L2_REQ: if (mem_rd_ready) state_q <= ST_L2_WAIT;
                ST_L2_WAIT: if (mem_rsp_valid) begin
                    if (mem_rsp_err || l2_bad)
                        {fault_q, pa_q, attr_q} <= {1'b1, {ADDR_W{1'b0}}, {ATTR_W{1'b0}}};
                    else
                        {fault_q, pa_q, attr_q} <= {1'b0, l2_pa, l2_attr};
                    state_q <= ST_DONE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Port outputs derived from the sequencer state and result registers.
    always_comb begin
        req_ready    = (state_q == ST_IDLE);
        mem_rd_valid = (state_q == ST_L1_REQ) || (state_q == ST_L2_REQ);
        done         = (state_q == ST_DONE);
        fault        = fault_q;
        pa           = pa_q;
        attr         = attr_q;
    end
endmodule

// File: rtl/xlate_walker_chk.sv
// Module: protocol checker for xlate_walker, attached by bind.
// Tracks the outstanding read locally and checks handshake and result rules.
module xlate_walker_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic        req_ready,
    input logic [31:0] req_va,
    input logic [31:0] req_ttb,
    input logic        mem_rd_valid,
    input logic        mem_rd_ready,
    input logic [31:0] mem_rd_addr,
    input logic        mem_rsp_valid,
    input logic        mem_rsp_err,
    input logic        done,
    input logic        fault,
    input logic [31:0] pa,
    input logic [1:0]  attr
);
    logic pending;

    // Outstanding-read tracker: set on accepted read, cleared on response.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pending <= 1'b0;
        else if (mem_rd_valid && mem_rd_ready)
            pending <= 1'b1;
        else if (mem_rsp_valid)
            pending <= 1'b0;
    end

    AST_FIRST_READ_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (mem_rd_valid &&
            mem_rd_addr == {$past(req_ttb[31:14]), $past(req_va[31:20]), 2'b00})); // R1
    AST_FAULT_ZERO_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        (done && fault) |-> (pa == 32'd0 && attr == 2'd0)); // R9
    AST_ERR_ENDS_WALK: assert property (@(posedge clk) disable iff (!rst_n)
        (pending && mem_rsp_valid && mem_rsp_err) |=> (done && fault)); // R9
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R10
    AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready); // R10
    AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
        pending |-> !mem_rd_valid); // R10
    AST_READ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_valid && !mem_rd_ready) |=> (mem_rd_valid && $stable(mem_rd_addr))); // R12
endmodule

bind xlate_walker xlate_walker_chk u_xlate_walker_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .req_va        (req_va),
    .req_ttb       (req_ttb),
    .mem_rd_valid  (mem_rd_valid),
    .mem_rd_ready  (mem_rd_ready),
    .mem_rd_addr   (mem_rd_addr),
    .mem_rsp_valid (mem_rsp_valid),
    .mem_rsp_err   (mem_rsp_err),
    .done          (done),
    .fault         (fault),
    .pa            (pa),
    .attr          (attr)
);

// File: tb/test_xlate_walker.sv
// Bench: directed scenarios, each task checking its own walks against a
// reference model written from the requirements.
module test_xlate_walker;
    localparam int LAT = 2;
    localparam logic [31:0] TTB = 32'h0004_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_va = '0;
    logic [31:0] req_ttb = '0;
    logic        req_tiny_en = 1'b0;
    logic        mem_rd_valid;
    logic        mem_rd_ready;
    logic [31:0] mem_rd_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_data = '0;
    logic        mem_rsp_err = 1'b0;
    logic        done;
    logic        fault;
    logic [31:0] pa;
    logic [1:0]  attr;

    int tests = 0;
    int fails = 0;
    int cycles = 0;

    logic [31:0] mem [logic [31:0]];
    logic [31:0] addr_log [256];
    int          nreads = 0;
    logic        err_en = 1'b0;
    logic [31:0] err_addr = '0;
    int          stall_cnt = 0;
    int          stall_target = 0;
    logic        pend = 1'b0;
    int          lat_left = 0;
    logic [31:0] pend_addr = '0;

    always #4 clk = ~clk;

    xlate_walker i_xlate_walker (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_va(req_va), .req_ttb(req_ttb), .req_tiny_en(req_tiny_en),
        .mem_rd_valid(mem_rd_valid), .mem_rd_ready(mem_rd_ready), .mem_rd_addr(mem_rd_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data), .mem_rsp_err(mem_rsp_err),
        .done(done), .fault(fault), .pa(pa), .attr(attr)
    );

    assign mem_rd_ready = (stall_cnt >= stall_target);

    function automatic logic [31:0] rd(input logic [31:0] a);
        return mem.exists(a) ? mem[a] : 32'd0;
    endfunction

    // Memory responder: one read at a time, fixed latency, optional error.
    always @(posedge clk) begin
        cycles <= cycles + 1;
        mem_rsp_valid <= 1'b0;
        if (mem_rd_valid && !mem_rd_ready) stall_cnt <= stall_cnt + 1;
        if (mem_rd_valid && mem_rd_ready) begin
            pend      <= 1'b1;
            lat_left  <= LAT;
            pend_addr <= mem_rd_addr;
            addr_log[nreads[7:0]] <= mem_rd_addr;
            nreads    <= nreads + 1;
        end else if (pend) begin
            if (lat_left == 0) begin
                mem_rsp_valid <= 1'b1;
                mem_rsp_err   <= err_en && (pend_addr == err_addr);
                mem_rsp_data  <= rd(pend_addr);
                pend          <= 1'b0;
            end else begin
                lat_left <= lat_left - 1;
            end
        end
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %08h expected %08h", req, act, exp);
        end
    endtask

    // Reference translation built from R1..R9.
    task automatic model(input logic [31:0] va, input logic [31:0] ttb, input logic tiny,
                         output logic [31:0] e_pa, output logic [1:0] e_attr, output logic e_fault,
                         output int e_n, output logic [31:0] a0, output logic [31:0] a1);
        logic [31:0] d, s;
        e_pa = '0; e_attr = '0; e_fault = 1'b0; a1 = '0; e_n = 1;
        a0 = {ttb[31:14], va[31:20], 2'b00};
        d  = rd(a0);
        if (err_en && err_addr == a0) e_fault = 1'b1;
        else if (d[1:0] == 2'b00) e_fault = 1'b1;
        else if (d[1:0] == 2'b11 && !tiny) e_fault = 1'b1;
        else if (d[1:0] == 2'b10) begin
            e_pa = {d[31:20], va[19:0]}; e_attr = d[3:2];
        end else begin
            e_n = 2;
            a1 = (d[1:0] == 2'b01) ? {d[31:10], va[19:12], 2'b00} : {d[31:12], va[19:10], 2'b00};
            s = rd(a1);
            if ((err_en && err_addr == a1) || s[1:0] == 2'b00) e_fault = 1'b1;
            else begin
                e_attr = s[3:2];
                case (s[1:0])
                    2'b01:   e_pa = {s[31:16], va[15:0]};
                    2'b10:   e_pa = {s[31:12], va[11:0]};
                    default: e_pa = {s[31:10], va[9:0]};
                endcase
            end
        end
        if (e_fault) begin e_pa = '0; e_attr = '0; end
    endtask

    // Run one walk, optionally disturbing the inputs, and check everything seen.
    task automatic run_walk(input logic [31:0] va, input logic tiny, input bit scramble, input string tag);
        logic [31:0] e_pa, a0, a1;
        logic [1:0]  e_attr;
        logic        e_fault;
        int          e_n, base, waited;
        model(va, TTB, tiny, e_pa, e_attr, e_fault, e_n, a0, a1);
        base = nreads;
        @(negedge clk);
        req_va = va; req_ttb = TTB; req_tiny_en = tiny; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        check(req_ready == 1'b0, {tag, " R10 busy"}, {31'd0, req_ready}, 32'd0);
        if (scramble) begin
            req_va = ~va; req_ttb = 32'h0F0F_C000; req_tiny_en = ~tiny;
        end
        waited = 0;
        while (!done && waited < 200) begin
            @(negedge clk);
            waited++;
        end
        check(done == 1'b1, {tag, " R10 done"}, {31'd0, done}, 32'd1);
        check(fault == e_fault, {tag, " fault R2 R3 R7 R9 R11"}, {31'd0, fault}, {31'd0, e_fault});
        check(pa == e_pa, {tag, " pa R4 R8 R9 R11"}, pa, e_pa);
        check(attr == e_attr, {tag, " attr R4 R7"}, {30'd0, attr}, {30'd0, e_attr});
        check(nreads - base == e_n, {tag, " read count R2 R3 R4"}, nreads - base, e_n);
        check(addr_log[base[7:0]] == a0, {tag, " first addr R1"}, addr_log[base[7:0]], a0);
        if (e_n == 2)
            check(addr_log[base[7:0] + 8'd1] == a1, {tag, " second addr R5 R6"},
                  addr_log[base[7:0] + 8'd1], a1);
        @(negedge clk);
        check(done == 1'b0 && req_ready == 1'b1, {tag, " R10 pulse"}, {30'd0, done, req_ready}, 32'd1);
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check(done == 0 && fault == 0 && pa == 0 && req_ready == 1 && mem_rd_valid == 0,
              "reset R10", pa, 32'd0);
        rst_n = 1'b1;
    endtask

    task automatic t_section;
        mem[{TTB[31:14], 12'h123, 2'b00}] = 32'hABC0_000E;
        run_walk(32'h1234_5678, 1'b0, 1'b0, "section R4");
        check(pa == 32'hABC4_5678, "section literal R4", pa, 32'hABC4_5678);
    endtask

    task automatic t_l1_fault;
        run_walk(32'h4000_0000, 1'b1, 1'b0, "l1 invalid R2");
    endtask

    task automatic t_coarse;
        mem[{TTB[31:14], 12'h234, 2'b00}] = 32'h0010_0401;
        mem[32'h0010_0558] = 32'h7777_700A;
        mem[32'h0010_05A8] = 32'h8888_0005;
        run_walk(32'h2345_6789, 1'b0, 1'b0, "coarse small R5 R8");
        run_walk(32'h2346_ABCD, 1'b0, 1'b0, "coarse large R5 R8");
    endtask

    task automatic t_fine;
        mem[{TTB[31:14], 12'h345, 2'b00}] = 32'h0020_3003;
        mem[32'h0020_3678] = 32'h9999_9C0F;
        run_walk(32'h3456_7ABC, 1'b1, 1'b0, "fine tiny R6 R8");
        check(pa == 32'h9999_9EBC, "tiny literal R8", pa, 32'h9999_9EBC);
        run_walk(32'h3456_7ABC, 1'b0, 1'b0, "fine gated R3");
    endtask

    task automatic t_l2_fault;
        run_walk(32'h2347_0000, 1'b0, 1'b0, "l2 invalid R7");
    endtask

    task automatic t_errors;
        err_en = 1'b1;
        err_addr = {TTB[31:14], 12'h123, 2'b00};
        run_walk(32'h1234_5678, 1'b0, 1'b0, "l1 error R9");
        err_addr = 32'h0010_0558;
        run_walk(32'h2345_6789, 1'b0, 1'b0, "l2 error R9");
        err_en = 1'b0;
    endtask

    task automatic t_capture;
        run_walk(32'h2345_6789, 1'b0, 1'b1, "scrambled R11");
        run_walk(32'h3456_7ABC, 1'b1, 1'b1, "scrambled fine R11");
    endtask

    task automatic t_stall;
        stall_target = stall_cnt + 3;
        run_walk(32'h2346_ABCD, 1'b0, 1'b0, "stalled R12");
        stall_target = stall_cnt + 2;
        run_walk(32'h1234_5678, 1'b0, 1'b0, "stalled section R12");
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    always @(negedge clk) begin
        if (cycles > 100000) begin
            tests++;
            fails++;
            $display("FAIL watchdog R10: actual %0d expected %0d", cycles, 100000);
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_section();
        t_l1_fault();
        t_coarse();
        t_fine();
        t_l2_fault();
        t_errors();
        t_capture();
        t_stall();
        repeat (4) @(negedge clk);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule